// File: doc/BRIEF.md
# I2C Target Receive Event Queue

This block sits behind the byte-level engine of an I2C target. It turns each received data byte, and each stop or repeated-start condition seen on the bus, into an entry of a small queue. Each entry holds an eight-bit byte next to seven framing flags. Software reads the flags of the oldest entry without disturbing the queue, so it can tell which address a byte was written to, whether the byte opened a transfer, and where the bus framing changed.

A pop request removes the oldest entry. It is the data-register read in the register map. Stop and repeated-start conditions occupy entries of their own, with a zero data byte, and are removed with the same pop. While any entry is waiting, a level-sensitive service request is raised.

When all eight slots are taken, the block tells the engine that it has no room. A byte that arrives anyway is discarded, and the newest stored entry is marked so that software knows a nack followed it. Events that arrive in the same clock are stored in a fixed order: the data byte, then the stop, then the repeated start. Any of them that find no free slot are discarded.

Top module: `i2c_tgt_rxq`

## Requirements
- R1: A data entry has flag bit 0 set when the byte was addressed to target address 1 (`rx_to_addr2`=0) and bit 1 set when it was addressed to address 2. Bit 2 copies `rx_nak_sent` and bit 3 copies `rx_tmo_nak`. The entry's data is the received byte.
- R2: Flag bit 4 is set on the first data byte after a start or a repeated start, and on no later byte of that transfer.
- R3: A stop condition stores an entry whose flags are exactly bit 6 (0x40), and a repeated start stores an entry whose flags are exactly bit 5 (0x20). Both carry data 0x00 and leave the queue only through a pop.
- R4: `head_flags` and `head_data` show the oldest entry without removing it. Both read as zero while the queue is empty.
- R5: A pop removes exactly the oldest entry. A pop on an empty queue has no effect.
- R6: A data byte, a stop and a repeated start in the same cycle are stored in that order. A pop in the same cycle as a write removes the old head.
- R7: `rx_room` is low exactly when 8 entries are stored. A data byte that arrives then is discarded and sets flag bit 2 of the newest stored entry.
- R8: A stop or repeated start that finds no free slot is discarded and stores no entry.
- R9: `svc_irq` is high exactly while at least one entry is stored. It follows the queue one cycle after the write or pop.
- R10: After reset the queue is empty, `svc_irq` is low, `rx_room` is high and no start is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte_vld | input | 1 | A data byte was received this cycle |
| rx_byte | input | 8 | Received data byte |
| rx_to_addr2 | input | 1 | The byte was addressed to target address 2 (0: address 1) |
| rx_nak_sent | input | 1 | The engine answered the byte with a nack |
| rx_tmo_nak | input | 1 | The byte was nacked because of a timeout |
| bus_start | input | 1 | A start condition was seen |
| bus_rstart | input | 1 | A repeated start condition was seen |
| bus_stop | input | 1 | A stop condition was seen |
| rx_room | output | 1 | At least one slot is free, so the next byte can be acked |
| head_flags | output | 7 | Flags of the oldest entry |
| head_data | output | 8 | Data of the oldest entry |
| rd_pop | input | 1 | Remove the oldest entry |
| svc_irq | output | 1 | Service request, high while entries are waiting |

## Verification
The queue is driven with several input patterns, each chosen to tell a specific fault apart:
- Single bytes to each address separate the address-1 and address-2 flag bits.
- A start followed by two bytes shows whether the first-byte flag is cleared after its first use.
- A byte and a stop in the same cycle expose an entry-ordering error.
- A pop in the same cycle as a write exposes a miscounted level.
- Filling all eight slots and pushing one more byte with a stop separates three faults: an overwrite, a lost nack mark and a stored framing entry.
- Filling seven slots and delivering data, stop and repeated start together shows that only the first lane wins the last slot.

// File: rtl/i2c_tgt_rxq_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, flag positions and the queue entry type.
// Assumes one received byte is always eight bits wide.
package i2c_tgt_rxq_pkg;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 7;
    localparam int NLANE  = 3;   // data, stop, repeated start

    localparam int FB_ADDR1 = 0;
    localparam int FB_ADDR2 = 1;
    localparam int FB_NAK   = 2;
    localparam int FB_TMO   = 3;
    localparam int FB_FIRST = 4;
    localparam int FB_RSTRT = 5;
    localparam int FB_STOP  = 6;

    localparam int LANE_DATA  = 0;
    localparam int LANE_STOP  = 1;
    localparam int LANE_RSTRT = 2;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [BYTE_W-1:0] value;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_lane_sel.sv
`timescale 1ns/1ps
// Lane selector: grants same-cycle write requests in lane order while free
// slots remain, and gives each granted lane its offset from the write pointer.
// Assumes the occupancy input is the registered level, so a pop in the same
// cycle does not free a slot for these writes.
module rxq_lane_sel #(
    parameter int DEPTH = 8,
    parameter int NL    = 3,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int OW   = $clog2(NL + 1)
) (
    input  logic [NL-1:0]         lane_req,
    input  logic [CW-1:0]         level,
    output logic [NL-1:0]         lane_acc,
    output logic [NL-1:0]         lane_drop,
    output logic [NL-1:0][OW-1:0] lane_off,
    output logic [OW-1:0]         acc_num
);
    logic [CW:0] room;

    // Grant requests lowest lane first until the free slots are used up.
    always_comb begin
        logic [OW-1:0] taken;
        room  = (CW+1)'(DEPTH) - {1'b0, level};
        taken = '0;
        lane_acc = '0;
        lane_off = '0;
        for (int k = 0; k < NL; k++) begin
            lane_off[k] = taken;
            if (lane_req[k] && ((CW+1)'(taken) < room)) begin
                lane_acc[k] = 1'b1;
                taken = taken + OW'(1);
            end
        end
        acc_num   = taken;
        lane_drop = lane_req & ~lane_acc;
    end
endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
// Entry store: circular buffer with several write lanes per cycle, one pop,
// and a mark that sets the nack flag of the newest entry.
// Assumes DEPTH is a power of two and that writes never exceed free slots.
module rxq_store
    import i2c_tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NL    = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int OW   = $clog2(NL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NL-1:0]         wr_en,
    input  rxq_entry_t [NL-1:0]   wr_ent,
    input  logic [NL-1:0][OW-1:0] wr_off,
    input  logic [OW-1:0]         wr_num,
    input  logic                  pop_req,
    input  logic                  mark_nak,
    output rxq_entry_t            head,
    output logic [CW-1:0]         level
);
    rxq_entry_t        mem [DEPTH];
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_ptr;
    logic              pop_ok;

    assign pop_ok = pop_req && (level != '0);

    // Advance pointers and occupancy by granted writes and valid pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(pop_ok);
            wr_ptr <= wr_ptr + AW'(wr_num);
            level  <= level + CW'(wr_num) - CW'(pop_ok);
        end
    end

    // Store granted lanes at their offsets and apply the overflow nack mark.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NL; k++) begin
            if (wr_en[k]) begin
                mem[wr_ptr + AW'(wr_off[k])] <= wr_ent[k];
            end
        end
        if (mark_nak) begin
            mem[wr_ptr - AW'(1)].flags[FB_NAK] <= 1'b1;
        end
    end

    // Present the oldest entry, or zero when nothing is stored.
    always_comb begin
        head = (level != '0) ? mem[rd_ptr] : '0;
    end
endmodule

// File: rtl/i2c_tgt_rxq.sv
`timescale 1ns/1ps
// I2C target receive event queue: builds flagged entries from the byte
// engine's event strobes, stores them in lane order and presents the oldest.
// Assumes each strobe is a one-cycle pulse per bus event.
module i2c_tgt_rxq
    import i2c_tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int OW   = $clog2(NLANE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_to_addr2,
    input  logic              rx_nak_sent,
    input  logic              rx_tmo_nak,
    input  logic              bus_start,
    input  logic              bus_rstart,
    input  logic              bus_stop,
    output logic              rx_room,
    output logic [FLAG_W-1:0] head_flags,
    output logic [BYTE_W-1:0] head_data,
    input  logic              rd_pop,
    output logic              svc_irq
);
    logic                     first_pend;
    logic [NLANE-1:0]         lane_req;
    logic [NLANE-1:0]         lane_acc;
    logic [NLANE-1:0]         lane_drop;
    logic [NLANE-1:0][OW-1:0] lane_off;
    logic [OW-1:0]            acc_num;
    rxq_entry_t [NLANE-1:0]   lane_ent;
    rxq_entry_t               head;
    logic [CW-1:0]            level;
    logic                     mark_nak;

    // Remember that a start was seen until the next data byte consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pend <= 1'b0;
        end else if (bus_start || bus_rstart) begin
            first_pend <= 1'b1;
        end else if (rx_byte_vld) begin
            first_pend <= 1'b0;
        end
    end

    // Build one candidate entry per lane in storage order.
    always_comb begin
        lane_req = '0;
        lane_ent = '0;
        lane_req[LANE_DATA]  = rx_byte_vld;
        lane_req[LANE_STOP]  = bus_stop;
        lane_req[LANE_RSTRT] = bus_rstart;
        lane_ent[LANE_DATA].value           = rx_byte;
        lane_ent[LANE_DATA].flags[FB_ADDR1] = !rx_to_addr2;
        lane_ent[LANE_DATA].flags[FB_ADDR2] = rx_to_addr2;
        lane_ent[LANE_DATA].flags[FB_NAK]   = rx_nak_sent;
        lane_ent[LANE_DATA].flags[FB_TMO]   = rx_tmo_nak;
        lane_ent[LANE_DATA].flags[FB_FIRST] = first_pend;
        lane_ent[LANE_STOP].flags[FB_STOP]   = 1'b1;
        lane_ent[LANE_RSTRT].flags[FB_RSTRT] = 1'b1;
    end

    rxq_lane_sel #(.DEPTH(DEPTH), .NL(NLANE)) sel_i (
        .lane_req  (lane_req),
        .level     (level),
        .lane_acc  (lane_acc),
        .lane_drop (lane_drop),
        .lane_off  (lane_off),
        .acc_num   (acc_num)
    );

    // A discarded data byte marks the newest stored entry as nack-followed.
    assign mark_nak = lane_drop[LANE_DATA] && (level != '0);

    rxq_store #(.DEPTH(DEPTH), .NL(NLANE)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lane_acc),
        .wr_ent   (lane_ent),
        .wr_off   (lane_off),
        .wr_num   (acc_num),
        .pop_req  (rd_pop),
        .mark_nak (mark_nak),
        .head     (head),
        .level    (level)
    );

    assign head_flags = head.flags;
    assign head_data  = head.value;
    assign svc_irq    = (level != '0);
    assign rx_room    = (level != CW'(DEPTH));
endmodule

// File: rtl/i2c_tgt_rxq_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of the receive event queue.
// Assumes it is bound to every instance of the top module.
module i2c_tgt_rxq_chk
    import i2c_tgt_rxq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_byte_vld,
    input logic              bus_rstart,
    input logic              bus_stop,
    input logic              rx_room,
    input logic [FLAG_W-1:0] head_flags,
    input logic [BYTE_W-1:0] head_data,
    input logic              rd_pop,
    input logic              svc_irq
);
    a_r4_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_irq |-> (head_flags == '0 && head_data == '0));

    a_r7_full_means_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_room |-> svc_irq);

    a_r5_head_held_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_irq && !rd_pop) |=> ($stable(head_data) && $stable(head_flags[6:3])
                                  && $stable(head_flags[1:0])));

    a_r9_quiet_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_irq && !rx_byte_vld && !bus_stop && !bus_rstart) |=> !svc_irq);

    a_r1_one_address: assert property (@(posedge clk) disable iff (!rst_n)
        !(head_flags[FB_ADDR1] && head_flags[FB_ADDR2]));

    a_r3_frame_entry_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (head_flags[FB_STOP] || head_flags[FB_RSTRT]) |-> head_data == '0);

    a_r2_first_only_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        head_flags[FB_FIRST] |-> $countones(head_flags[1:0]) == 1);
endmodule

bind i2c_tgt_rxq i2c_tgt_rxq_chk chk_i (.*);

// File: tb/i2c_tgt_rxq_tb.sv
`timescale 1ns/1ps
// Bench: table-driven vectors, then directed reset, overflow and ordering tests.
module i2c_tgt_rxq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_to_addr2 = 1'b0;
    logic       rx_nak_sent = 1'b0;
    logic       rx_tmo_nak = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_rstart = 1'b0;
    logic       bus_stop = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rx_room;
    logic [6:0] head_flags;
    logic [7:0] head_data;
    logic       svc_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_tgt_rxq dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_to_addr2(rx_to_addr2), .rx_nak_sent(rx_nak_sent), .rx_tmo_nak(rx_tmo_nak),
        .bus_start(bus_start), .bus_rstart(bus_rstart), .bus_stop(bus_stop),
        .rx_room(rx_room), .head_flags(head_flags), .head_data(head_data),
        .rd_pop(rd_pop), .svc_irq(svc_irq)
    );

    typedef struct packed {
        logic vld, a2, nak, tmo, st, rs, sp, pop;
        logic [7:0] b;
        logic       irq;
        logic [6:0] fl;
        logic [7:0] dt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 1'b0, 7'h00, 8'h00},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA5, 1'b1, 7'h11, 8'hA5},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h3C, 1'b1, 7'h11, 8'hA5},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 7'h01, 8'h3C},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h77, 1'b1, 7'h01, 8'h3C},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 7'h01, 8'h77},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 7'h40, 8'h00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b0, 7'h00, 8'h00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b1, 7'h20, 8'h00},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h5A, 1'b1, 7'h20, 8'h00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 7'h1A, 8'h5A},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h81, 1'b1, 7'h06, 8'h81},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b0, 7'h00, 8'h00}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // One clock of stimulus; outputs are sampled 2 ns after the edge.
    task automatic cyc(input logic vld, a2, nak, tmo, st, rs, sp, pop, input logic [7:0] b);
        rx_byte_vld = vld; rx_to_addr2 = a2; rx_nak_sent = nak; rx_tmo_nak = tmo;
        bus_start = st; bus_rstart = rs; bus_stop = sp; rd_pop = pop; rx_byte = b;
        @(posedge clk);
        #2;
        rx_byte_vld = 0; rx_to_addr2 = 0; rx_nak_sent = 0; rx_tmo_nak = 0;
        bus_start = 0; bus_rstart = 0; bus_stop = 0; rd_pop = 0; rx_byte = 8'h00;
    endtask

    task automatic push(input logic [7:0] b);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, b);
    endtask

    task automatic pop1();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check("R10 svc_irq after reset", 32'(svc_irq), 32'd0);
        check("R10 rx_room after reset", 32'(rx_room), 32'd1);
        check("R10/R4 head_flags after reset", 32'(head_flags), 32'h0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            cyc(VT[v].vld, VT[v].a2, VT[v].nak, VT[v].tmo, VT[v].st, VT[v].rs,
                VT[v].sp, VT[v].pop, VT[v].b);
            check($sformatf("R9 svc_irq vector %0d", v), 32'(svc_irq), 32'(VT[v].irq));
            check($sformatf("R1/R2/R3/R6 head_flags vector %0d", v), 32'(head_flags), 32'(VT[v].fl));
            check($sformatf("R4/R5 head_data vector %0d", v), 32'(head_data), 32'(VT[v].dt));
        end

        // R7/R8: fill all slots, then overflow a byte together with a stop
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 8'h00);
        for (int k = 0; k < 8; k++) push(8'(k));
        check("R7 rx_room low when full", 32'(rx_room), 32'd0);
        cyc(1, 0, 0, 0, 0, 0, 1, 0, 8'hEE);
        check("R7 rx_room stays low", 32'(rx_room), 32'd0);
        for (int k = 0; k < 8; k++) begin
            logic [6:0] ef;
            ef = (k == 0) ? 7'h11 : ((k == 7) ? 7'h05 : 7'h01);
            check($sformatf("R7 drained data %0d", k), 32'(head_data), 32'(k));
            check($sformatf("R7/R2 drained flags %0d", k), 32'(head_flags), 32'(ef));
            pop1();
        end
        check("R8 no stop entry kept after overflow", 32'(svc_irq), 32'd0);
        check("R9 rx_room back high", 32'(rx_room), 32'd1);

        // R5: pop on an empty queue has no effect
        pop1();
        check("R5 empty pop irq", 32'(svc_irq), 32'd0);
        push(8'h42);
        check("R5 byte after empty pop", 32'(head_data), 32'h42);
        check("R5 flags after empty pop", 32'(head_flags), 32'h01);
        pop1();
        check("R5 single pop empties", 32'(svc_irq), 32'd0);

        // R6/R8: seven stored, then data+stop+rstart in one cycle
        for (int k = 0; k < 7; k++) push(8'(8'h10 + k));
        cyc(1, 0, 0, 0, 0, 1, 1, 0, 8'h99);
        check("R6 last slot taken by data", 32'(rx_room), 32'd0);
        for (int k = 0; k < 7; k++) pop1();
        check("R6 data lane wins last slot", 32'(head_data), 32'h99);
        check("R6 data lane flags, no nack", 32'(head_flags), 32'h01);
        pop1();
        check("R8 stop and rstart dropped", 32'(svc_irq), 32'd0);
        push(8'h33);
        check("R2 first-byte after repeated start", 32'(head_flags), 32'h11);

        // R10: reset with entries stored
        push(8'h44);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        check("R10 irq cleared by reset", 32'(svc_irq), 32'd0);
        check("R10 head cleared by reset", 32'(head_data), 32'h0);
        push(8'h55);
        check("R10 no start pending after reset", 32'(head_flags), 32'h01);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule